// File: doc/BRIEF.md
# Acquisition Front-End Register Bank

This block is the host-side register file of a four-channel sampling front end. A host reaches it over a 16-bit I/O bus made of an address, a write strobe, a read strobe and separate write and read data words. The bank holds three stored registers:

- an acquisition setup word, for channel code, clock choice, channel enables, coupling and power-down;
- a trigger setup word;
- an interrupt/DMA control word.

It turns writes to certain offsets into single-cycle command pulses, for start, FIFO reset and terminal-count clear. It also returns a status word built from live flags and from two sticky flags.

The converter, the sample FIFO storage and the DMA engine sit outside the block. The bank sees them only as flag inputs, a data word on the FIFO read path, and pulse outputs. Offset 0x12 is shared. A read there returns status, and a write there loads the interrupt/DMA control word, which cannot be read back. The interrupt request output follows the enabled event sources.

Top module: `acq_regbank`

## Requirements
- R1: After reset, `cfg_q`, `trig_q`, `ctl_q` and `bus_rdata` are zero, both sticky flags are clear and `irq` is low.
- R2: A write at offset 0x00 loads `cfg_q` with `bus_wdata & 0x1FFF` at the clock edge. A read at 0x00 returns that value. The bit fields are: bits 2:0 channel code, bits 4:3 clock select, bits 6:5 divisor shift, bit 7 pair-0 enable, bit 8 pair-1 enable, bit 9 pair-0 AC coupling, bit 10 pair-1 AC coupling, bit 11 analog power-down and bit 12 digital power-down.
- R3: A write at offset 0x02 loads `trig_q` with `bus_wdata & 0x0013`. Bits 1:0 are the trigger mode (2 post-trigger, 3 delayed) and bit 4 is the external trigger enable. A read at 0x02 returns the stored value.
- R4: A write at offset 0x12 loads `ctl_q` with `bus_wdata & 0x1BFF`. The bit fields are: bits 2:0 DMA channel, bit 3 DMA enable, bits 7:4 IRQ level, bit 8 FIFO interrupt enable, bit 9 half-full select and bit 11 terminal-count interrupt enable. Bit 12 selects demand-mode DMA. `ctl_q` changes on no other access.
- R5: A read at offset 0x12 returns status. The bits are: bit 0 `fifo_nempty`, bit 3 overflow sticky flag, bit 4 `acq_done`, bit 5 `cal_busy`, bit 6 interrupt pending, bit 7 terminal-count sticky flag, and bits 9:8 `board_id`. All other bits are zero. The status is sampled at the read edge.
- R6: While a write is presented at 0x06, 0x08 or 0x0E, `start_pulse`, `fifo_rst` or `tc_clr` is high, in that order of offsets. The strobe is high in that cycle only, and whatever data is written has no effect on any register. Reads at those offsets raise no strobe.
- R7: The terminal-count flag is set at the edge after `dma_tc` is high. It stays set until a write to 0x0E. When `dma_tc` and the clear arrive in the same cycle, the flag ends up set.
- R8: The overflow flag is set at the edge after `fifo_ovfl` is high. It stays set until a write to 0x08. When both arrive in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when either of two sources is active. The first is `ctl_q[11]` together with the terminal-count flag. The second is `ctl_q[8]` together with either `fifo_half` (if `ctl_q[9]` is 1) or `fifo_nempty` (if `ctl_q[9]` is 0).
- R10: A read at 0x0A returns `fifo_word` and raises `fifo_pop` for that cycle.
- R11: A write at any other offset changes no register. A read at any other offset, including odd offsets, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered at the read edge |
| fifo_nempty | input | 1 | Sample FIFO holds data |
| fifo_half | input | 1 | Sample FIFO at least half full |
| fifo_ovfl | input | 1 | Sample FIFO overflow event |
| acq_done | input | 1 | Acquisition finished |
| cal_busy | input | 1 | Offset calibration running |
| board_id | input | 2 | Board identifier |
| dma_tc | input | 1 | DMA terminal-count event |
| fifo_word | input | 16 | Word at the FIFO head |
| cfg_q | output | 16 | Acquisition setup word |
| trig_q | output | 16 | Trigger setup word |
| ctl_q | output | 16 | Interrupt/DMA control word |
| start_pulse | output | 1 | Software start command |
| fifo_rst | output | 1 | FIFO and trigger reset command |
| tc_clr | output | 1 | Terminal-count clear command |
| fifo_pop | output | 1 | FIFO head consumed |
| irq | output | 1 | Interrupt request |

## Verification
The stimulus draws random offsets over the whole 5-bit space, including odd and unmapped ones, with random data and random flag inputs. Random data on the stored offsets separates correct field masking from pass-through of undefined bits. Random data on the strobe offsets shows whether writes there leak into any register. Directed sequences set a sticky flag, hold it over idle cycles, clear it, and present set and clear together, which separates set-priority from clear-priority. Reads of offset 0x12 taken between control writes show whether the shared address keeps status and control apart.

// File: rtl/acq_regbank.sv
module acq_regbank #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          fifo_nempty,
  input  logic          fifo_half,
  input  logic          fifo_ovfl,
  input  logic          acq_done,
  input  logic          cal_busy,
  input  logic [1:0]    board_id,
  input  logic          dma_tc,
  input  logic [DW-1:0] fifo_word,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] trig_q,
  output logic [DW-1:0] ctl_q,
  output logic          start_pulse,
  output logic          fifo_rst,
  output logic          tc_clr,
  output logic          fifo_pop,
  output logic          irq
);
  localparam logic [AW-1:0] A_CFG   = AW'(5'h00);
  localparam logic [AW-1:0] A_TRIG  = AW'(5'h02);
  localparam logic [AW-1:0] A_START = AW'(5'h06);
  localparam logic [AW-1:0] A_FRST  = AW'(5'h08);
  localparam logic [AW-1:0] A_FIFO  = AW'(5'h0A);
  localparam logic [AW-1:0] A_TCCLR = AW'(5'h0E);
  localparam logic [AW-1:0] A_STAT  = AW'(5'h12);
  localparam logic [DW-1:0] CFG_M   = DW'(16'h1FFF);
  localparam logic [DW-1:0] TRIG_M  = DW'(16'h0013);
  localparam logic [DW-1:0] CTL_M   = DW'(16'h1BFF);

  logic          tc_q, ovfl_q, pend;
  logic [DW-1:0] status, rd_mux;

  assign start_pulse = bus_wr && bus_addr == A_START;
  assign fifo_rst    = bus_wr && bus_addr == A_FRST;
  assign tc_clr      = bus_wr && bus_addr == A_TCCLR;
  assign fifo_pop    = bus_rd && bus_addr == A_FIFO;

  assign pend = (ctl_q[11] && tc_q) ||
                (ctl_q[8] && (ctl_q[9] ? fifo_half : fifo_nempty));
  assign irq  = pend;

  assign status = DW'({board_id, tc_q, pend, cal_busy, acq_done, ovfl_q,
                       2'b00, fifo_nempty});

  always_comb begin
    case (bus_addr)
      A_CFG:   rd_mux = cfg_q;
      A_TRIG:  rd_mux = trig_q;
      A_FIFO:  rd_mux = fifo_word;
      A_STAT:  rd_mux = status;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      trig_q    <= '0;
      ctl_q     <= '0;
      tc_q      <= 1'b0;
      ovfl_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CFG)  cfg_q  <= bus_wdata & CFG_M;
      if (bus_wr && bus_addr == A_TRIG) trig_q <= bus_wdata & TRIG_M;
      if (bus_wr && bus_addr == A_STAT) ctl_q  <= bus_wdata & CTL_M;
      tc_q   <= dma_tc || (tc_q && !tc_clr);
      ovfl_q <= fifo_ovfl || (ovfl_q && !fifo_rst);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/acq_regbank_chk.sv
module acq_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_rdata,
  input logic [15:0] ctl_q,
  input logic        dma_tc,
  input logic        fifo_ovfl,
  input logic        tc_q,
  input logic        ovfl_q,
  input logic        start_pulse,
  input logic        fifo_rst,
  input logic        tc_clr
);
  logic unmapped;
  assign unmapped = !(bus_addr inside {5'h00, 5'h02, 5'h0A, 5'h12});

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, fifo_rst, tc_clr}));
  p_tc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tc |=> tc_q);
  p_tc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !tc_clr) |=> tc_q);
  p_ovfl_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovfl |=> ovfl_q);
  p_ovfl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl_q && !fifo_rst) |=> ovfl_q);
  p_ctl_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 5'h12) |=> $stable(ctl_q));
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> bus_rdata == 16'h0000);
endmodule

bind acq_regbank acq_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ctl_q(ctl_q), .dma_tc(dma_tc),
  .fifo_ovfl(fifo_ovfl), .tc_q(tc_q), .ovfl_q(ovfl_q),
  .start_pulse(start_pulse), .fifo_rst(fifo_rst), .tc_clr(tc_clr)
);

// File: tb/sim_acq_regbank.sv
`timescale 1ns/1ps
module sim_acq_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, fifo_word = '0;
  logic fifo_nempty = 0, fifo_half = 0, fifo_ovfl = 0, acq_done = 0, cal_busy = 0, dma_tc = 0;
  logic [1:0] board_id = '0;
  logic [15:0] bus_rdata, cfg_q, trig_q, ctl_q;
  logic start_pulse, fifo_rst, tc_clr, fifo_pop, irq;

  int checks = 0, fails = 0;
  logic [15:0] cfg_m = 0, trig_m = 0, ctl_m = 0;
  logic tc_m = 0, ov_m = 0;

  always #2.5 clk = ~clk;

  acq_regbank u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return (ctl_m[11] && tc_m) || (ctl_m[8] && (ctl_m[9] ? fifo_half : fifo_nempty));
  endfunction

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return cfg_m;
      5'h02: return trig_m;
      5'h0A: return fifo_word;
      5'h12: return {6'b0, board_id, tc_m, exp_irq(), cal_busy, acq_done, ov_m, 2'b00, fifo_nempty};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string rtag(input logic [4:0] a);
    case (a)
      5'h00: return "R2";
      5'h02: return "R3";
      5'h0A: return "R10";
      5'h12: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic step(input logic [4:0] a, input bit w, input bit r, input logic [15:0] d,
                      input bit tc, input bit ov, input logic [7:0] fl);
    logic [15:0] e;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    dma_tc = tc; fifo_ovfl = ov;
    fifo_nempty = fl[0]; fifo_half = fl[1]; acq_done = fl[2]; cal_busy = fl[3];
    board_id = fl[5:4]; fifo_word = {fl, ~fl};
    #1;
    chk("R6 start", {15'b0, start_pulse}, {15'b0, w && a == 5'h06});
    chk("R6 fiforst", {15'b0, fifo_rst}, {15'b0, w && a == 5'h08});
    chk("R6 tcclr", {15'b0, tc_clr}, {15'b0, w && a == 5'h0E});
    chk("R10 pop", {15'b0, fifo_pop}, {15'b0, r && a == 5'h0A});
    chk("R9 irq", {15'b0, irq}, {15'b0, exp_irq()});
    chk("R2 cfg", cfg_q, cfg_m);
    chk("R3 trig", trig_q, trig_m);
    chk("R4 ctl", ctl_q, ctl_m);
    e = exp_rd(a);
    if (w && a == 5'h00) cfg_m = d & 16'h1FFF;
    if (w && a == 5'h02) trig_m = d & 16'h0013;
    if (w && a == 5'h12) ctl_m = d & 16'h1BFF;
    tc_m = tc || (tc_m && !(w && a == 5'h0E));
    ov_m = ov || (ov_m && !(w && a == 5'h08));
    @(posedge clk); #1;
    if (r) chk(rtag(a), bus_rdata, e);
  endtask

  task automatic idle();
    step(5'h01, 0, 0, 16'h0, 0, 0, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cfg", cfg_q, 16'h0); chk("R1 trig", trig_q, 16'h0);
    chk("R1 ctl", ctl_q, 16'h0); chk("R1 rdata", bus_rdata, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);            // R1 sticky flags clear
    // R2/R3/R4 masking
    step(5'h00, 1, 0, 16'hFFFF, 0, 0, 8'h00);
    step(5'h00, 0, 1, 0, 0, 0, 8'h00);
    step(5'h02, 1, 0, 16'hFFFF, 0, 0, 8'h00);
    step(5'h02, 0, 1, 0, 0, 0, 8'h00);
    step(5'h12, 1, 0, 16'hFFFF, 0, 0, 8'h00);
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);           // R5 status, not ctl
    // R6 strobe data ignored
    step(5'h06, 1, 0, 16'h0000, 0, 0, 8'h00);
    step(5'h08, 1, 0, 16'h1234, 0, 0, 8'h00);
    step(5'h0E, 1, 0, 16'hFFFF, 0, 0, 8'h00);
    step(5'h06, 0, 1, 0, 0, 0, 8'h00);
    // R7 sticky terminal count, irq via bit 11
    step(5'h12, 1, 0, 16'h0800, 0, 0, 8'h00);
    step(5'h01, 0, 0, 0, 1, 0, 8'h00);
    repeat (4) idle();
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);
    step(5'h0E, 1, 0, 0, 1, 0, 8'h00);           // R7 set wins
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);
    step(5'h0E, 1, 0, 0, 0, 0, 8'h00);
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);
    // R8 overflow
    step(5'h01, 0, 0, 0, 0, 1, 8'h00);
    repeat (3) idle();
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);
    step(5'h08, 1, 0, 0, 0, 1, 8'h00);
    step(5'h08, 1, 0, 0, 0, 0, 8'h00);
    step(5'h12, 0, 1, 0, 0, 0, 8'h00);
    // R9 FIFO interrupt select
    step(5'h12, 1, 0, 16'h0100, 0, 0, 8'h01);
    step(5'h12, 1, 0, 16'h0300, 0, 0, 8'h01);
    step(5'h01, 0, 0, 0, 0, 0, 8'h02);
    // R11 unmapped
    step(5'h1F, 1, 0, 16'hFFFF, 0, 0, 8'h00);
    step(5'h1F, 0, 1, 0, 0, 0, 8'hFF);
    step(5'h03, 0, 1, 0, 0, 0, 8'hFF);
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] a;
      bit w, r;
      a = 5'($urandom % 32);
      w = ($urandom % 2) == 0;
      r = !w && ($urandom % 3) != 0;
      step(a, w, r, 16'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0, 8'($urandom));
    end
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule